// File: doc/BRIEF.md
# Float to Integer Converter with Selectable Rounding

This block converts an IEEE-754 single-precision value into a 32-bit two's-complement signed integer. The caller chooses one of five rounding behaviours for each input, through a 3-bit code that travels with the operand. An input is accepted on any cycle where its valid strobe is high. The block has no backpressure, so one operand can enter on every cycle. Each result comes out exactly two cycles later, together with its own valid strobe and two flags.

The first stage takes the operand apart into sign, biased exponent and fraction. It places the significand on a fixed-point grid that has 32 integer bits and 32 fraction bits, and it reduces everything below the first fraction bit to a guard bit and a sticky bit. The second stage decides whether to add one to the magnitude under the selected mode. It then applies the sign and saturates anything that does not fit. The inexact flag reports that some nonzero fraction was thrown away. The invalid flag reports NaN, infinity or a result outside the 32-bit range.

Top module: `float_to_int_rnd`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, outValid is 0 and outInt, outInvalid and outInexact are all 0.
- R2: The operand uses the standard single-precision layout: sign in bit 31, biased exponent (bias 127) in bits 30:23, fraction in bits 22:0. If inValid is high at clock edge k, then outValid is high after edge k+1 and carries that operand's result. If inValid is low at edge k, then outValid is low after edge k+1. Back-to-back operands give back-to-back results, in order.
- R3: Mode code 0 rounds toward zero, so 7.5 gives 7 and -7.5 gives -7. Codes 5, 6 and 7 behave exactly like code 0.
- R4: Mode code 1 rounds toward positive infinity, so 7.5 gives 8 and -7.5 gives -7.
- R5: Mode code 2 rounds toward negative infinity, so 7.5 gives 7 and -7.5 gives -8.
- R6: Mode code 3 rounds to the nearest integer and moves an exact half away from zero, so 8.5 gives 9 and -8.5 gives -9.
- R7: Mode code 4 rounds to the nearest integer and moves an exact half to the even neighbour, so 7.5 gives 8, 8.5 gives 8 and -8.5 gives -8.
- R8: outInexact is 1 exactly when the operand had a nonzero fraction below the integer point and the result is not invalid. It is 0 whenever outInvalid is 1.
- R9: A NaN operand (exponent 255, nonzero fraction) gives 0x80000000, with outInvalid 1 and outInexact 0, in every mode.
- R10: Infinity, and any rounded result above 2147483647 or below -2147483648, saturates to 0x7FFFFFFF for a positive sign or 0x80000000 for a negative sign, with outInvalid 1. An operand of exactly -2^31 converts to 0x80000000 with outInvalid 0.
- R11: A zero or denormal operand (exponent 0), of either sign, gives 0 with both flags 0 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand strobe |
| inFloat | input | 32 | Single-precision operand |
| inMode | input | 3 | Rounding mode code for this operand |
| outValid | output | 1 | Result strobe, two cycles after inValid |
| outInt | output | 32 | Signed integer result |
| outInvalid | output | 1 | NaN, infinity or out-of-range result |
| outInexact | output | 1 | A nonzero fraction was discarded |

## Verification
Each result, with both of its flags, is due on the second rising edge after the edge that captured its operand. The bench drives inputs on falling edges and keeps a two-deep record of what it drove. On every falling edge it compares the outputs with the entry from two falling edges earlier, before it drives anything new. Idle slots are placed between operands, and those slots must show outValid low. That tests the strobe path separately from the data. The expected value for every operand comes from a real-number calculation in the bench, with explicit floor, ceiling and half tests. Exponents are swept across the whole region where rounding and saturation change, with every mode code and both signs.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

  typedef enum logic [2:0] {
    RM_TRUNC = 3'd0,
    RM_CEIL  = 3'd1,
    RM_FLOOR = 3'd2,
    RM_AWAY  = 3'd3,
    RM_EVEN  = 3'd4
  } round_mode_e;

  typedef struct packed {
    logic loadAlign;
    logic loadRound;
  } f2i_strobe_t;

  // Codes outside the defined set fall back to truncation
  function automatic round_mode_e decodeMode(input logic [2:0] code);
    case (code)
      3'd1:    decodeMode = RM_CEIL;
      3'd2:    decodeMode = RM_FLOOR;
      3'd3:    decodeMode = RM_AWAY;
      3'd4:    decodeMode = RM_EVEN;
      default: decodeMode = RM_TRUNC;
    endcase
  endfunction

endpackage

// File: rtl/f2i_ctrl.sv
module f2i_ctrl
  import f2i_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  output f2i_strobe_t strobe,
  output logic        outValid
);

  logic alignValid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alignValid <= 1'b0;
      outValid   <= 1'b0;
    end else begin
      alignValid <= inValid;
      outValid   <= alignValid;
    end
  end

  always_comb begin
    strobe.loadAlign = inValid;
    strobe.loadRound = alignValid;
  end

  // R2: a result strobe is always backed by an operand two edges earlier
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> $past(inValid, 2));

  // R2: an operand accepted out of reset is never dropped
  assert_no_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inValid, 2) && $past(rst_n, 2) && $past(rst_n, 1)) |-> outValid);

endmodule

// File: rtl/f2i_datapath.sv
module f2i_datapath
  import f2i_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int BIAS  = 127,
  parameter int INT_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  f2i_strobe_t            strobe,
  input  logic [EXP_W+MAN_W:0]   inFloat,
  input  logic [2:0]             inMode,
  output logic [INT_W-1:0]       outInt,
  output logic                   outInvalid,
  output logic                   outInexact
);

  localparam int FLT_W  = EXP_W + MAN_W + 1;
  localparam int FIX_W  = 2 * INT_W;
  localparam int SIG_W  = MAN_W + 1;
  localparam logic [EXP_W-1:0] LOW_EXP = EXP_W'(BIAS + MAN_W - INT_W);
  localparam logic [EXP_W-1:0] OVF_EXP = EXP_W'(BIAS + INT_W - 1);
  localparam logic [INT_W-1:0] POS_MAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] NEG_MIN = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W:0]   POS_LIM = {2'b00, {(INT_W-1){1'b1}}};
  localparam logic [INT_W:0]   NEG_LIM = {2'b01, {(INT_W-1){1'b0}}};

  // ---------------- stage 1: unpack and align ----------------
  logic             signIn;
  logic [EXP_W-1:0] expIn;
  logic [MAN_W-1:0] fracIn;
  logic             isNan, isZero, isMinInt, isOvf;
  logic [EXP_W-1:0] shAmt;
  logic [FIX_W-1:0] fixWide;
  logic [INT_W-1:0] intPart;
  logic             guardBit, stickyBit;

  always_comb begin
    signIn   = inFloat[FLT_W-1];
    expIn    = inFloat[FLT_W-2 -: EXP_W];
    fracIn   = inFloat[MAN_W-1:0];
    isNan    = (expIn == '1) && (fracIn != '0);
    isZero   = (expIn == '0);
    isMinInt = signIn && (expIn == OVF_EXP) && (fracIn == '0);
    isOvf    = (expIn >= OVF_EXP) && !isNan && !isMinInt;
    shAmt    = expIn - LOW_EXP;
    fixWide  = FIX_W'({1'b1, fracIn}) << shAmt;
    if (isZero) begin
      intPart   = '0;
      guardBit  = 1'b0;
      stickyBit = 1'b0;
    end else if (expIn < LOW_EXP) begin
      // value lies well below one half: all of it is sticky
      intPart   = '0;
      guardBit  = 1'b0;
      stickyBit = 1'b1;
    end else begin
      intPart   = fixWide[FIX_W-1 -: INT_W];
      guardBit  = fixWide[INT_W-1];
      stickyBit = |fixWide[INT_W-2:0];
    end
  end

  logic             s1Sign, s1Nan, s1Ovf, s1Guard, s1Sticky;
  logic [INT_W-1:0] s1Int;
  round_mode_e      s1Mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1Sign   <= 1'b0;
      s1Nan    <= 1'b0;
      s1Ovf    <= 1'b0;
      s1Guard  <= 1'b0;
      s1Sticky <= 1'b0;
      s1Int    <= '0;
      s1Mode   <= RM_TRUNC;
    end else if (strobe.loadAlign) begin
      s1Sign   <= signIn;
      s1Nan    <= isNan;
      s1Ovf    <= isOvf;
      s1Guard  <= guardBit;
      s1Sticky <= stickyBit;
      s1Int    <= intPart;
      s1Mode   <= decodeMode(inMode);
    end
  end

  // ---------------- stage 2: round, sign, saturate ----------------
  logic             discard, incr, rangeErr;
  logic [INT_W:0]   magSum;
  logic [INT_W-1:0] resNext;
  logic             invNext, inexNext;

  always_comb begin
    discard = s1Guard || s1Sticky;
    case (s1Mode)
      RM_CEIL:  incr = !s1Sign && discard;
      RM_FLOOR: incr = s1Sign && discard;
      RM_AWAY:  incr = s1Guard;
      RM_EVEN:  incr = s1Guard && (s1Sticky || s1Int[0]);
      default:  incr = 1'b0;
    endcase
    magSum   = {1'b0, s1Int} + (INT_W+1)'(incr);
    rangeErr = s1Sign ? (magSum > NEG_LIM) : (magSum > POS_LIM);
    if (s1Nan) begin
      resNext = NEG_MIN;
      invNext = 1'b1;
    end else if (s1Ovf || rangeErr) begin
      resNext = s1Sign ? NEG_MIN : POS_MAX;
      invNext = 1'b1;
    end else begin
      resNext = s1Sign ? (~magSum[INT_W-1:0] + 1'b1) : magSum[INT_W-1:0];
      invNext = 1'b0;
    end
    inexNext = discard && !invNext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outInt     <= '0;
      outInvalid <= 1'b0;
      outInexact <= 1'b0;
    end else if (strobe.loadRound) begin
      outInt     <= resNext;
      outInvalid <= invNext;
      outInexact <= inexNext;
    end
  end

  // R11: zero and denormal operands align to an exact zero
  assert_zero_align_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.loadAlign && expIn == '0) |=> (s1Int == '0 && !s1Guard && !s1Sticky));

  // R9: NaN yields the most negative code and flags it
  assert_nan_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.loadRound && s1Nan) |=> (outInt == NEG_MIN && outInvalid && !outInexact));

  // R10: exponent overflow saturates toward the operand's sign
  assert_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.loadRound && s1Ovf && !s1Nan) |=>
      (outInvalid && outInt == ($past(s1Sign) ? NEG_MIN : POS_MAX)));

  // R8: the inexact flag is never raised beside the invalid flag
  assert_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    outInvalid |-> !outInexact);

  // R3: truncation returns the aligned magnitude, only negated
  assert_trunc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.loadRound && s1Mode == RM_TRUNC && !s1Nan && !s1Ovf) |=>
      (outInt == ($past(s1Sign) ? (~$past(s1Int) + 1'b1) : $past(s1Int))));

endmodule

// File: rtl/float_to_int_rnd.sv
module float_to_int_rnd
  import f2i_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic [31:0] inFloat,
  input  logic [2:0]  inMode,
  output logic        outValid,
  output logic [31:0] outInt,
  output logic        outInvalid,
  output logic        outInexact
);

  f2i_strobe_t strobe;

  f2i_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  f2i_datapath #(
    .EXP_W (8),
    .MAN_W (23),
    .BIAS  (127),
    .INT_W (32)
  ) i_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .inFloat    (inFloat),
    .inMode     (inMode),
    .outInt     (outInt),
    .outInvalid (outInvalid),
    .outInexact (outInexact)
  );

endmodule

// File: tb/test_float_to_int_rnd.sv
module test_float_to_int_rnd;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inFloat = '0;
  logic [2:0]  inMode = '0;
  logic        outValid;
  logic [31:0] outInt;
  logic        outInvalid, outInexact;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        p0Valid = 1'b0, p1Valid = 1'b0;
  logic [31:0] p0F = '0, p1F = '0;
  logic [2:0]  p0M = '0, p1M = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  float_to_int_rnd i_float_to_int_rnd (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inFloat(inFloat),
    .inMode(inMode), .outValid(outValid), .outInt(outInt),
    .outInvalid(outInvalid), .outInexact(outInexact)
  );

  // Reference model: real arithmetic with explicit floor/ceil/half tests
  task automatic model(input logic [31:0] f, input logic [2:0] md,
                       output logic [31:0] eInt, output logic eInv,
                       output logic eInex, output string tag);
    logic       s;
    int         e;
    logic [22:0] fr;
    real v, tr, rem, absRem, r, half, stepDir;
    s  = f[31];
    e  = int'(f[30:23]);
    fr = f[22:0];
    eInv = 1'b0; eInex = 1'b0; eInt = '0;
    case (md)
      3'd1: tag = "R4";
      3'd2: tag = "R5";
      3'd3: tag = "R6";
      3'd4: tag = "R7";
      default: tag = "R3";
    endcase
    if (e == 255 && fr != 0) begin
      tag = "R9"; eInt = 32'h80000000; eInv = 1'b1;
    end else if (e == 255) begin
      tag = "R10"; eInt = s ? 32'h80000000 : 32'h7FFFFFFF; eInv = 1'b1;
    end else if (e == 0) begin
      tag = "R11";
    end else begin
      v = real'({1'b1, fr}) * (2.0 ** (real'(e) - 150.0));
      if (s) v = -v;
      tr = (v >= 0.0) ? $floor(v) : $ceil(v);
      rem = v - tr;
      absRem = (rem < 0.0) ? -rem : rem;
      stepDir = (v < 0.0) ? -1.0 : 1.0;
      half = tr / 2.0;
      case (md)
        3'd1: r = $ceil(v);
        3'd2: r = $floor(v);
        3'd3: r = (absRem >= 0.5) ? tr + stepDir : tr;
        3'd4: begin
          if (absRem > 0.5) r = tr + stepDir;
          else if (absRem == 0.5 && half != $floor(half)) r = tr + stepDir;
          else r = tr;
        end
        default: r = tr;
      endcase
      if (r > 2147483647.0) begin
        tag = "R10"; eInt = 32'h7FFFFFFF; eInv = 1'b1;
      end else if (r < -2147483648.0) begin
        tag = "R10"; eInt = 32'h80000000; eInv = 1'b1;
      end else begin
        eInt  = 32'($rtoi(r));
        eInex = (v != tr);
      end
    end
  endtask

  task automatic compareSlot();
    logic [31:0] eInt;
    logic eInv, eInex;
    string tag;
    checks++;
    if (p1Valid) begin
      model(p1F, p1M, eInt, eInv, eInex, tag);
      if (!outValid) begin
        errors++;
        $display("FAIL R2 operand %h mode %0d: outValid actual 0 expected 1", p1F, p1M);
      end else if (outInt !== eInt || outInvalid !== eInv) begin
        errors++;
        $display("FAIL %s operand %h mode %0d: actual %h inv %b expected %h inv %b",
                 tag, p1F, p1M, outInt, outInvalid, eInt, eInv);
      end else if (outInexact !== eInex) begin
        errors++;
        $display("FAIL R8 operand %h mode %0d: inexact actual %b expected %b",
                 p1F, p1M, outInexact, eInex);
      end
    end else if (outValid !== 1'b0) begin
      errors++;
      $display("FAIL R2 idle slot: outValid actual %b expected 0", outValid);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] f, input logic [2:0] md);
    @(negedge clk);
    compareSlot();
    p1Valid = p0Valid; p1F = p0F; p1M = p0M;
    p0Valid = v; p0F = f; p0M = md;
    inValid = v; inFloat = f; inMode = md;
  endtask

  function automatic logic [22:0] fracPat(input int i);
    case (i)
      0: fracPat = 23'h000000;
      1: fracPat = 23'h400000;
      2: fracPat = 23'h000001;
      3: fracPat = 23'h7FFFFF;
      4: fracPat = 23'h200000;
      default: fracPat = 23'h5A5A5A;
    endcase
  endfunction

  function automatic logic [31:0] special(input int i);
    case (i)
      0:  special = 32'h7FC00000;  // NaN
      1:  special = 32'hFF800001;  // NaN, negative
      2:  special = 32'h7F800000;  // +inf
      3:  special = 32'hFF800000;  // -inf
      4:  special = 32'hCF000000;  // -2^31 exact
      5:  special = 32'h4F000000;  // +2^31
      6:  special = 32'hCF000001;  // below -2^31
      7:  special = 32'h00000001;  // denormal
      8:  special = 32'h80400000;  // negative denormal
      9:  special = 32'h00000000;  // +0
      10: special = 32'h80000000;  // -0
      11: special = 32'h40F00000;  // 7.5
      12: special = 32'h41080000;  // 8.5
      13: special = 32'hC0F00000;  // -7.5
      14: special = 32'hC1080000;  // -8.5
      15: special = 32'h3F000000;  // 0.5
      16: special = 32'hBF000000;  // -0.5
      17: special = 32'h3EFFFFFF;  // just below 0.5
      18: special = 32'h412D70A4;  // about 10.84
      default: special = 32'h4EFFFFFF; // largest float below 2^31
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    n = 0;
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || outInt !== '0 || outInvalid !== 1'b0 || outInexact !== 1'b0) begin
      errors++;
      $display("FAIL R1 during reset: actual v%b %h %b %b expected 0 00000000 0 0",
               outValid, outInt, outInvalid, outInexact);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || outInt !== '0 || outInvalid !== 1'b0 || outInexact !== 1'b0) begin
      errors++;
      $display("FAIL R1 after release: actual v%b %h %b %b expected 0 00000000 0 0",
               outValid, outInt, outInvalid, outInexact);
    end

    // Special operands and named halves in every mode code (R3..R11)
    for (int sp = 0; sp < 20; sp++) begin
      for (int md = 0; md < 8; md++) begin
        step(1'b1, special(sp), 3'(md));
      end
      step(1'b0, 32'hDEADBEEF, 3'd3); // idle slot, R2
    end

    // Sweep of exponents across rounding and saturation region
    for (int e = 100; e <= 160; e++) begin
      for (int pi = 0; pi < 6; pi++) begin
        for (int s = 0; s < 2; s++) begin
          for (int md = 0; md < 8; md++) begin
            step(1'b1, {1'(s), 8'(e), fracPat(pi)}, 3'(md));
            n++;
            if (n % 7 == 0) step(1'b0, '0, 3'd0);
          end
        end
      end
    end

    step(1'b0, '0, 3'd0);
    step(1'b0, '0, 3'd0);
    step(1'b0, '0, 3'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule